// File: doc/BRIEF.md
# Time-Shared Multi-Channel IIR Filter Engine

This block runs fifteen independent low-rate IIR filters on a single second-order-section datapath. Each filter is four biquad sections in series. A sample arrives with its channel number. A phase counter then walks that channel's four sections in turn. For every section it reads the section's history from a single-port state memory, performs five multiply-accumulate steps on one shared multiplier, and writes the updated history back. An input mux feeds the shared section with the fresh sample for the first section and with the result of the previous section for the later ones. When the last section finishes, the filtered value leaves the block tagged with its channel.

Samples enter through a valid/ready stream and results leave through a second valid/ready stream. The engine takes one sample at a time. `in_ready` is high only when no computation is running and no result is waiting to be taken. A result is held unchanged until the consumer raises `out_ready`. A slow consumer therefore stalls the input side rather than losing data. Coefficients are loaded through a simple index/data/write-enable port, and a write is taken only while the engine is not computing.

Top module: `fbq_engine`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1, and every section's history (two past inputs and two past outputs) is zero.
- R2: Each section computes y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2. Data is 16-bit signed and coefficients are 16-bit signed with 14 fraction bits. Coefficient index = ((channel·4)+section)·5 + tap, where tap 0=b0, 1=b1, 2=b2, 3=a1 and 4=a2.
- R3: Section 0 takes the accepted sample. Sections 1 to 3 each take the output of the section before them. `out_data` is the output of section 3.
- R4: Each section output is (acc + 2^13) shifted arithmetically right by 14, then saturated to the range −32768..32767.
- R5: Each channel keeps its own history. `out_chan` equals the `in_chan` of the sample that produced the result.
- R6: `in_ready` is low in the cycle after a sample is accepted. `out_valid` rises exactly 28 clock edges after the accepting edge (7 cycles per section). The state memory is never read and written in the same cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold their values and `in_ready` stays low. `out_valid` falls after an edge on which `out_ready` is high.
- R8: A coefficient write is taken when no computation is running, including the cycle in which a sample is accepted, and then applies to that sample. A write presented while the engine is computing has no effect.
- R9: A reset during a computation abandons it. No result appears and the history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine can accept a sample |
| in_chan | input | 4 | Channel of the input sample (0..14) |
| in_data | input | 16 | Input sample, signed |
| cf_we | input | 1 | Coefficient write enable |
| cf_idx | input | 9 | Coefficient index per R2 |
| cf_data | input | 16 | Coefficient value, signed, 14 fraction bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_chan | output | 4 | Channel of the result |
| out_data | output | 16 | Filtered result, signed |

## Verification
A coefficient write and a sample acceptance can fall in the same cycle, because both depend only on the engine being free. The bench raises `cf_we` together with `in_valid` to change the first-section gain of channel 0, and it expects the halved output from that very sample. It then repeats the write while the engine is computing and checks that this sample and the next one still show the earlier gain. A reset that lands in the middle of a computation is also provoked, and the bench judges it by the absence of a result and by a zero output from the channel's next sample.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int FRAC  = 14;
  localparam int AW    = 40;
  localparam int N_TAP = 5;

  typedef logic signed [DW-1:0] smp_t;

  typedef struct packed {
    smp_t x1;
    smp_t x2;
    smp_t y1;
    smp_t y2;
  } sec_state_t;

  typedef enum logic [2:0] {TAP_B0, TAP_B1, TAP_B2, TAP_A1, TAP_A2} tap_e;

  localparam logic signed [AW-1:0] RND_HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] SAT_HI   = (AW'(1) << (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] SAT_LO   = ~SAT_HI;

  function automatic smp_t round_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    r = (a + RND_HALF) >>> FRAC;
    if (r > SAT_HI) return DW'(SAT_HI);
    if (r < SAT_LO) return DW'(SAT_LO);
    return DW'(r);
  endfunction
endpackage

// File: rtl/fbq_seq.sv
module fbq_seq #(
  parameter int N_CH  = 15,
  parameter int N_SEC = 4,
  parameter int N_TAP = 5,
  parameter int CHW   = $clog2(N_CH),
  parameter int SECW  = (N_SEC > 1) ? $clog2(N_SEC) : 1,
  parameter int SAW   = $clog2(N_CH * N_SEC),
  parameter int IDXW  = $clog2(N_CH * N_SEC * N_TAP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            out_ready,
  input  logic [CHW-1:0]  in_chan,
  output logic            in_ready,
  output logic            out_valid,
  output logic            busy,
  output logic [CHW-1:0]  cur_chan,
  output logic [SAW-1:0]  st_addr,
  output logic            st_rd,
  output logic            st_we,
  output logic [IDXW-1:0] cf_rd_idx,
  output logic [2:0]      tap,
  output logic            acc_clr,
  output logic            mac_en,
  output logic            load_in,
  output logic            load_fb,
  output logic            emit
);
  localparam int PH_LAST = N_TAP + 1;
  localparam int PHW     = $clog2(PH_LAST + 1);

  logic [PHW-1:0]  ph;
  logic [SECW-1:0] sec;
  logic            accept;
  logic            last_sec;

  assign in_ready = !busy && !out_valid;
  assign accept   = in_valid && in_ready;
  assign last_sec = (sec == SECW'(N_SEC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ph        <= '0;
      sec       <= '0;
      cur_chan  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        ph       <= '0;
        sec      <= '0;
        cur_chan <= in_chan;
      end else if (busy) begin
        if (ph == PHW'(PH_LAST)) begin
          ph <= '0;
          if (last_sec) busy <= 1'b0;
          else          sec  <= sec + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
      if (emit)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // address and strobe pattern derived from the counters
  assign st_addr   = SAW'(int'(cur_chan) * N_SEC + int'(sec));
  assign st_rd     = busy && (ph == '0);
  assign st_we     = busy && (ph == PHW'(PH_LAST));
  assign mac_en    = busy && (ph != '0) && (ph <= PHW'(N_TAP));
  assign tap       = mac_en ? 3'(ph - PHW'(1)) : 3'd0;
  assign cf_rd_idx = IDXW'(int'(st_addr) * N_TAP + int'(tap));
  assign acc_clr   = st_rd;
  assign load_in   = accept;
  assign load_fb   = st_we;
  assign emit      = st_we && last_sec;

  p_emit_done_r6: assert property (@(posedge clk) disable iff (rst)
    emit |=> (!busy && out_valid && !in_ready));

  p_phase_bound_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ph == '0));
endmodule

// File: rtl/fbq_coef_store.sv
module fbq_coef_store
  import fbq_pkg::*;
#(
  parameter int DEPTH = 300,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lock,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic signed [CW-1:0] wr_data,
  input  logic [IDXW-1:0]      rd_idx,
  output logic signed [CW-1:0] rd_data
);
  logic signed [CW-1:0] mem [DEPTH];
  logic                 in_range;

  assign in_range = (wr_idx < IDXW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en && !lock && in_range) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  p_coef_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock && in_range) |=> (mem[$past(wr_idx)] == $past(mem[wr_idx])));
endmodule

// File: rtl/fbq_state_ram.sv
module fbq_state_ram
  import fbq_pkg::*;
#(
  parameter int DEPTH = 60,
  parameter int ADW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [ADW-1:0] addr,
  input  logic           rd_en,
  input  logic           we,
  input  sec_state_t     wdata,
  output sec_state_t     rdata
);
  sec_state_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we)    mem[addr] <= wdata;
      if (rd_en) rdata     <= mem[addr];
    end
  end

  p_single_port_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && we));
endmodule

// File: rtl/fbq_dp.sv
module fbq_dp
  import fbq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  smp_t                 in_data,
  input  logic                 load_in,
  input  logic                 load_fb,
  input  logic                 emit,
  input  logic                 acc_clr,
  input  logic                 mac_en,
  input  logic [2:0]           tap,
  input  logic signed [CW-1:0] coef,
  input  sec_state_t           st_q,
  output sec_state_t           st_wdata,
  output smp_t                 out_data
);
  smp_t                 x_cur;
  smp_t                 opnd;
  smp_t                 y;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] prod;

  always_comb begin
    case (tap_e'(tap))
      TAP_B1:  opnd = st_q.x1;
      TAP_B2:  opnd = st_q.x2;
      TAP_A1:  opnd = st_q.y1;
      TAP_A2:  opnd = st_q.y2;
      default: opnd = x_cur;
    endcase
  end

  assign prod = AW'(opnd) * AW'(coef);
  assign y    = round_sat(acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      x_cur    <= '0;
      out_data <= '0;
    end else begin
      if (acc_clr)     acc <= '0;
      else if (mac_en) acc <= (tap >= 3'(TAP_A1)) ? acc - prod : acc + prod;
      if (load_in)      x_cur <= in_data;
      else if (load_fb) x_cur <= y;
      if (emit) out_data <= y;
    end
  end

  assign st_wdata = '{x1: x_cur, x2: st_q.x1, y1: y, y2: st_q.y1};

  p_feed_mux_r3: assert property (@(posedge clk) disable iff (rst)
    !(load_in && load_fb));

  p_emit_feeds_out_r3: assert property (@(posedge clk) disable iff (rst)
    emit |=> (out_data == x_cur));
endmodule

// File: rtl/fbq_engine.sv
module fbq_engine
  import fbq_pkg::*;
#(
  parameter int N_CH  = 15,
  parameter int N_SEC = 4,
  parameter int CHW   = $clog2(N_CH),
  parameter int IDXW  = $clog2(N_CH * N_SEC * N_TAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CHW-1:0]       in_chan,
  input  logic signed [DW-1:0] in_data,
  input  logic                 cf_we,
  input  logic [IDXW-1:0]      cf_idx,
  input  logic signed [CW-1:0] cf_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CHW-1:0]       out_chan,
  output logic signed [DW-1:0] out_data
);
  localparam int N_SLOT = N_CH * N_SEC;
  localparam int SAW    = $clog2(N_SLOT);

  logic                 busy, st_rd, st_we, acc_clr, mac_en, load_in, load_fb, emit;
  logic [SAW-1:0]       st_addr;
  logic [IDXW-1:0]      cf_rd_idx;
  logic [2:0]           tap;
  logic signed [CW-1:0] coef;
  sec_state_t           st_q, st_wdata;

  fbq_seq #(.N_CH(N_CH), .N_SEC(N_SEC), .N_TAP(N_TAP), .CHW(CHW),
            .SAW(SAW), .IDXW(IDXW)) u_seq (
    .clk, .rst, .in_valid, .out_ready, .in_chan, .in_ready, .out_valid, .busy,
    .cur_chan(out_chan), .st_addr, .st_rd, .st_we, .cf_rd_idx, .tap,
    .acc_clr, .mac_en, .load_in, .load_fb, .emit
  );

  fbq_coef_store #(.DEPTH(N_SLOT * N_TAP), .IDXW(IDXW)) u_coef (
    .clk, .rst, .lock(busy), .wr_en(cf_we), .wr_idx(cf_idx), .wr_data(cf_data),
    .rd_idx(cf_rd_idx), .rd_data(coef)
  );

  fbq_state_ram #(.DEPTH(N_SLOT), .ADW(SAW)) u_state (
    .clk, .rst, .addr(st_addr), .rd_en(st_rd), .we(st_we), .wdata(st_wdata),
    .rdata(st_q)
  );

  fbq_dp u_dp (
    .clk, .rst, .in_data, .load_in, .load_fb, .emit, .acc_clr, .mac_en, .tap,
    .coef, .st_q, .st_wdata, .out_data
  );

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));
endmodule

// File: tb/fbq_engine_bench.sv
module fbq_engine_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 26;
  localparam int T_CH [NV] = '{0, 1, 2, 3, 4, 5, 1, 2, 4, 5, 0, 1, 2,
                               4, 5, 2, 4, 5, 5, 2, 2, 1, 1, 1, 1, 3};
  localparam int T_X  [NV] = '{123, 100, 1000, 100, 7, 10, 200, 0, 8, 0, -4567, -50, 0,
                               9, 0, 0, 10, 0, 0, 0, 0, 30000, 30000, -30000, -30000, -200};
  localparam int T_Y  [NV] = '{123, 100, 1000, 507, 0, 10, 300, 500, 0, 0, -4567, 150, 250,
                               7, -10, 125, 8, 0, 10, 63, 32, 29950, 32767, 0, -32768, -1012};

  logic               clk = 0, rst = 1;
  logic               in_valid = 0, in_ready, cf_we = 0, out_valid, out_ready = 0;
  logic [3:0]         in_chan = 0, out_chan;
  logic signed [15:0] in_data = 0, cf_data = 0, out_data;
  logic [8:0]         cf_idx = 0;
  int                 checks = 0, fails = 0;

  fbq_engine u_fbq_engine (
    .clk, .rst, .in_valid, .in_ready, .in_chan, .in_data, .cf_we, .cf_idx, .cf_data,
    .out_valid, .out_ready, .out_chan, .out_data
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int cidx(input int ch, input int sec, input int tp);
    return ((ch * 4) + sec) * 5 + tp;
  endfunction

  task automatic wcoef(input int idx, input int val);
    @(negedge clk);
    cf_we = 1; cf_idx = 9'(idx); cf_data = 16'(val);
    @(negedge clk);
    cf_we = 0;
  endtask

  // send one sample; optional coefficient write at cycle offset cf_off (0 = with the sample)
  task automatic run(input int ch, input int x, input int exp, input string tag,
                     input int cf_off, input int cf_i, input int cf_v);
    int n = 0;
    @(negedge clk);
    while (!in_ready && n < 200) begin @(negedge clk); n++; end
    in_valid = 1; in_chan = 4'(ch); in_data = 16'(x);
    if (cf_off == 0) begin cf_we = 1; cf_idx = 9'(cf_i); cf_data = 16'(cf_v); end
    @(negedge clk);
    in_valid = 0; cf_we = 0;
    chk("R6 in_ready low while busy", int'(in_ready), 0);
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk); n++;
      if (cf_off > 0 && n == cf_off) begin
        cf_we = 1; cf_idx = 9'(cf_i); cf_data = 16'(cf_v);
      end else cf_we = 0;
    end
    cf_we = 0;
    chk("R6 latency", n, 28);
    chk(tag, int'(out_data), exp);
    chk("R5 out_chan", int'(out_chan), ch);
    repeat (3) @(negedge clk);
    chk("R7 valid held", int'(out_valid), 1);
    chk("R7 data held", int'(out_data), exp);
    chk("R7 in_ready low while pending", int'(in_ready), 0);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk("R7 valid drops", int'(out_valid), 0);
    chk("R7 ready returns", int'(in_ready), 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);

    for (int ch = 0; ch < 6; ch++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 5; t++)
          wcoef(cidx(ch, s, t), (t == 0) ? 16384 : 0);
    wcoef(cidx(1, 0, 1), 16384);
    wcoef(cidx(2, 0, 3), -8192);
    for (int s = 0; s < 4; s++) wcoef(cidx(3, s, 0), 24576);
    wcoef(cidx(4, 1, 0), 0);
    wcoef(cidx(4, 1, 2), 16384);
    wcoef(cidx(5, 0, 4), 16384);

    // R1 zero history, R2 taps, R3 cascade, R4 rounding and saturation, R5 isolation
    for (int i = 0; i < NV; i++)
      run(T_CH[i], T_X[i], T_Y[i], "R2 R3 R4 R1 table result", -1, 0, 0);

    // R8: write in the acceptance cycle applies to that sample
    run(0, 1000, 500, "R8 write with accept", 0, cidx(0, 0, 0), 8192);
    // R8: write while busy is ignored
    run(0, 1000, 500, "R8 write while busy", 3, cidx(0, 0, 0), 0);
    run(0, 400, 200, "R8 busy write had no effect", -1, 0, 0);

    // R9: reset in the middle of a computation
    @(negedge clk);
    in_valid = 1; in_chan = 4'd2; in_data = 16'sd1000;
    @(negedge clk);
    in_valid = 0;
    repeat (10) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R9 in_ready after abort", int'(in_ready), 1);
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (out_valid) seen = 1;
      end
      chk("R9 no result after abort", seen, 0);
    end
    run(2, 0, 0, "R9 history cleared", -1, 0, 0);
    run(2, 1000, 1000, "R9 fresh start", -1, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule